// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block runs the conversion-and-readout sequence for a converter that samples two analog channels at the same instant. On a start request it raises a conversion strobe for one serial clock period, then clocks in a 34-bit serial frame. That frame carries two 14-bit two's complement results, and the block presents both on parallel outputs with a one-cycle valid pulse. The serial clock comes from dividing the system clock by a parameter. Because the converter may share that clock line with other devices, the block holds it low whenever no conversion is in progress.

The converter returns each conversion's samples during the following conversion. Every valid result therefore belongs to the previous strobe. A flag cleared at reset marks the first frame after reset as meaningless, and that frame produces no valid pulse. A minimum spacing between strobes, set in system clock cycles, keeps the conversion rate below the converter's limit. The block stays busy until that spacing has elapsed, and start requests made while busy are dropped.

Top module: `dual_adc_reader`

## Requirements
- R1: While reset is high and in the cycle after it is released, busy, the strobe, the serial clock and valid are low, and both results read zero.
- R2: A start request seen while idle raises the strobe and busy on the next clock edge. The strobe stays high for exactly CLK_DIV system cycles.
- R3: The serial clock is low whenever busy is low. Each serial period is CLK_DIV cycles, low for the first half and high for the second. A conversion gives exactly 2*SAMPLE_W+7 rising edges: one during the strobe and one per frame bit.
- R4: A frame bit is sampled on the serial clock's rising edge. The converter changes data after the falling edge. Frame bit 0 follows the strobe's period, and the frame order is 2 ignored bits, channel 0 MSB first, 2 ignored bits, channel 1 MSB first, 2 ignored bits.
- R5: The results reported for a conversion are the samples the converter took at the previous strobe.
- R6: The first frame after reset produces no valid pulse and leaves both results unchanged.
- R7: Both results change on the same clock edge, valid is high for exactly one cycle at that moment, and the results never change at any other time.
- R8: A start request made while busy is ignored and produces no extra strobe.
- R9: Successive strobe rising edges are at least MIN_GAP cycles apart. With start held high, the spacing is max((2*SAMPLE_W+7)*CLK_DIV+2, MIN_GAP).
- R10: For one conversion, busy stays high for max((2*SAMPLE_W+7)*CLK_DIV+1, MIN_GAP-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request one conversion and readout |
| busy | output | 1 | High from the strobe until the strobe spacing has elapsed |
| convStrobe | output | 1 | Active-high conversion start to the converter |
| serClk | output | 1 | Serial clock to the converter, low when idle |
| serData | input | 1 | Serial data from the converter |
| ch0Result | output | SAMPLE_W | Channel 0 result, signed |
| ch1Result | output | SAMPLE_W | Channel 1 result, signed |
| resultValid | output | 1 | One-cycle pulse when both results update |

## Verification
The assertions assume that the serial data input is stable around each rising edge of the serial clock. They also assume that startReq is a synchronous level that needs no debouncing. The bench's converter model changes the data line only on falling serial clock edges, which are two system cycles away from any sampling edge. It drives startReq only at the falling edge of the system clock. Reset is applied once in the middle of a frame, so the first-frame rule is exercised twice.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;
  // Ignored bits before channel 0, between channels, and after channel 1.
  localparam int LEAD_BITS = 2;
  localparam int MID_BITS  = 2;
  localparam int TAIL_BITS = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} ctlState_t;

  typedef struct packed {
    logic capture;  // sample serData on this edge
    logic finish;   // last serial period ends on this edge
  } dpCtl_t;
endpackage

// File: rtl/adcrd_ctrl.sv
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int CLK_DIV    = 4,
  parameter int FRAME_BITS = 34,
  parameter int MIN_GAP    = 34
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   startReq,
  output logic   busy,
  output logic   convOut,
  output logic   sclkOut,
  output dpCtl_t dpCtl
);
  localparam int HALF     = CLK_DIV / 2;
  localparam int PH_W     = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int PER_W    = $clog2(FRAME_BITS + 1);
  localparam int GAP_W    = $clog2(MIN_GAP + 1) + 1;
  localparam int LAST_PER = FRAME_BITS;

  ctlState_t          state;
  logic [PH_W-1:0]    phase;
  logic [PER_W-1:0]   period;
  logic [GAP_W-1:0]   gapCnt;
  logic               convReg;
  logic               sclkReg;
  logic               halfPoint;
  logic               periodEnd;

  assign halfPoint = (phase == PH_W'(HALF - 1));
  assign periodEnd = (phase == PH_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= '0;
      period  <= '0;
      gapCnt  <= '0;
      convReg <= 1'b0;
      sclkReg <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            state   <= ST_RUN;
            phase   <= '0;
            period  <= '0;
            gapCnt  <= '0;
            convReg <= 1'b1;
          end
        end
        ST_RUN: begin
          if (gapCnt != GAP_W'(MIN_GAP)) gapCnt <= gapCnt + 1'b1;
          if (periodEnd) begin
            sclkReg <= 1'b0;
            phase   <= '0;
            if (period == '0) convReg <= 1'b0;
            if (period == PER_W'(LAST_PER)) state <= ST_HOLD;
            else period <= period + 1'b1;
          end else begin
            if (halfPoint) sclkReg <= 1'b1;
            phase <= phase + 1'b1;
          end
        end
        ST_HOLD: begin
          if (gapCnt != GAP_W'(MIN_GAP)) gapCnt <= gapCnt + 1'b1;
          if (gapCnt >= GAP_W'(MIN_GAP - 2)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign convOut       = convReg;
  assign sclkOut       = sclkReg;
  assign dpCtl.capture = (state == ST_RUN) && halfPoint && (period != '0);
  assign dpCtl.finish  = (state == ST_RUN) && periodEnd && (period == PER_W'(LAST_PER));

  // Strobe spacing watcher, kept apart from the hold logic above.
  logic             convDly;
  logic             seenStrobe;
  logic [GAP_W-1:0] sinceStrobe;
  always_ff @(posedge clk) begin
    if (rst) begin
      convDly     <= 1'b0;
      seenStrobe  <= 1'b0;
      sinceStrobe <= '0;
    end else begin
      convDly <= convReg;
      if (convReg && !convDly) begin
        seenStrobe  <= 1'b1;
        sinceStrobe <= GAP_W'(1);
      end else if (sinceStrobe != GAP_W'(MIN_GAP)) begin
        sinceStrobe <= sinceStrobe + 1'b1;
      end
    end
  end

  // R3
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclkOut);
  // R2
  conv_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    convOut |-> busy);
  // R8
  conv_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
    busy && !convOut |=> !$rose(convOut));
  // R9
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (convReg && !convDly && seenStrobe) |-> (sinceStrobe >= GAP_W'(MIN_GAP)));
endmodule

// File: rtl/adcrd_dpath.sv
module adcrd_dpath
  import adcrd_pkg::*;
#(
  parameter int SAMPLE_W   = 14,
  parameter int FRAME_BITS = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  dpCtl_t                     dpCtl,
  input  logic                       serData,
  output logic signed [SAMPLE_W-1:0] ch0Out,
  output logic signed [SAMPLE_W-1:0] ch1Out,
  output logic                       validOut
);
  localparam int BIT_W     = $clog2(FRAME_BITS + 1);
  localparam int CH0_FIRST = LEAD_BITS;
  localparam int CH0_LAST  = CH0_FIRST + SAMPLE_W - 1;
  localparam int CH1_FIRST = CH0_LAST + 1 + MID_BITS;
  localparam int CH1_LAST  = CH1_FIRST + SAMPLE_W - 1;

  logic [BIT_W-1:0]    bitNo;
  logic [SAMPLE_W-1:0] ch0Sh;
  logic [SAMPLE_W-1:0] ch1Sh;
  logic                primed;
  logic                inCh0;
  logic                inCh1;

  assign inCh0 = (bitNo >= BIT_W'(CH0_FIRST)) && (bitNo <= BIT_W'(CH0_LAST));
  assign inCh1 = (bitNo >= BIT_W'(CH1_FIRST)) && (bitNo <= BIT_W'(CH1_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      bitNo    <= '0;
      ch0Sh    <= '0;
      ch1Sh    <= '0;
      primed   <= 1'b0;
      ch0Out   <= '0;
      ch1Out   <= '0;
      validOut <= 1'b0;
    end else begin
      validOut <= 1'b0;
      if (dpCtl.capture) begin
        bitNo <= bitNo + 1'b1;
        if (inCh0) ch0Sh <= {ch0Sh[SAMPLE_W-2:0], serData};
        if (inCh1) ch1Sh <= {ch1Sh[SAMPLE_W-2:0], serData};
      end
      if (dpCtl.finish) begin
        bitNo  <= '0;
        primed <= 1'b1;
        if (primed) begin
          ch0Out   <= $signed(ch0Sh);
          ch1Out   <= $signed(ch1Sh);
          validOut <= 1'b1;
        end
      end
    end
  end

  // Count of completed frames, independent of the primed flag.
  logic [1:0] framesSeen;
  always_ff @(posedge clk) begin
    if (rst) framesSeen <= '0;
    else if (dpCtl.finish && framesSeen != 2'd3) framesSeen <= framesSeen + 1'b1;
  end

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |=> !validOut);
  // R7
  results_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !validOut |-> ($stable(ch0Out) && $stable(ch1Out)));
  // R6
  first_frame_chk: assert property (@(posedge clk) disable iff (rst)
    validOut |-> (framesSeen >= 2'd2));
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader
  import adcrd_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int SAMPLE_W = 14,
  parameter int MIN_GAP  = 34
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       startReq,
  output logic                       busy,
  output logic                       convStrobe,
  output logic                       serClk,
  input  logic                       serData,
  output logic signed [SAMPLE_W-1:0] ch0Result,
  output logic signed [SAMPLE_W-1:0] ch1Result,
  output logic                       resultValid
);
  localparam int FRAME_BITS = LEAD_BITS + SAMPLE_W + MID_BITS + SAMPLE_W + TAIL_BITS;

  dpCtl_t dpCtl;

  adcrd_ctrl #(
    .CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS), .MIN_GAP(MIN_GAP)
  ) ctrlInst (
    .clk(clk), .rst(rst), .startReq(startReq), .busy(busy),
    .convOut(convStrobe), .sclkOut(serClk), .dpCtl(dpCtl)
  );

  adcrd_dpath #(
    .SAMPLE_W(SAMPLE_W), .FRAME_BITS(FRAME_BITS)
  ) dpathInst (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .serData(serData),
    .ch0Out(ch0Result), .ch1Out(ch1Result), .validOut(resultValid)
  );
endmodule

// File: tb/dual_adc_reader_test.sv
module dual_adc_reader_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 4;
  localparam int GAP  = 300;
  localparam int W    = 14;
  localparam int FB   = 2 * W + 6;
  localparam int PERS = FB + 1;
  localparam int EXP_SPACING = (PERS * DIV + 2 > GAP) ? PERS * DIV + 2 : GAP;
  localparam int EXP_BUSY    = (PERS * DIV + 1 > GAP - 1) ? PERS * DIV + 1 : GAP - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startReq = 1'b0;
  logic serData = 1'b0;
  logic busy, convStrobe, serClk, resultValid;
  logic signed [W-1:0] ch0Result, ch1Result;

  dual_adc_reader #(.CLK_DIV(DIV), .SAMPLE_W(W), .MIN_GAP(GAP)) uut (
    .clk(clk), .rst(rst), .startReq(startReq), .busy(busy),
    .convStrobe(convStrobe), .serClk(serClk), .serData(serData),
    .ch0Result(ch0Result), .ch1Result(ch1Result), .resultValid(resultValid)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model: samples at strobe, returns previous samples in the frame.
  logic [W-1:0] nextA = '0, nextB = '0, heldA = '0, heldB = '0;
  logic [FB-1:0] frame = '0;
  int bitIdx = FB;
  always @(posedge convStrobe) begin
    frame  = {2'b10, heldA, 2'b01, heldB, 2'b11};
    heldA  = nextA;
    heldB  = nextB;
    bitIdx = 0;
  end
  always @(negedge serClk) begin
    if (bitIdx < FB) begin
      serData = frame[FB-1-bitIdx];
      bitIdx++;
    end
  end

  // Monitors, sampled on the falling system clock edge.
  int cyc = 0, validCnt = 0, validRun = 0, widthBad = 0, idleBad = 0;
  int strobeCnt = 0, strobeCyc = 0, lastSpacing = 0;
  int convRun = 0, convWidth = 0, sclkRises = 0, busyRun = 0, busyLast = 0;
  logic signed [W-1:0] capA = '0, capB = '0;
  logic convPrev = 1'b0, sclkPrev = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (resultValid) begin
      validCnt++; validRun++;
      capA = ch0Result; capB = ch1Result;
      if (validRun > 1) widthBad++;
    end else validRun = 0;
    if (serClk && !busy) idleBad++;
    if (convStrobe && !convPrev) begin
      strobeCnt++;
      lastSpacing = cyc - strobeCyc;
      strobeCyc = cyc;
    end
    if (convStrobe) convRun++;
    else if (convRun > 0) begin convWidth = convRun; convRun = 0; end
    if (serClk && !sclkPrev) sclkRises++;
    if (busy) busyRun++;
    else if (busyRun > 0) begin busyLast = busyRun; busyRun = 0; end
    convPrev = convStrobe;
    sclkPrev = serClk;
  end

  task automatic run_conv(int a, int b);
    nextA = W'(a); nextB = W'(b);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 strobe", int'(convStrobe), 0);
    check("R1 serclk", int'(serClk), 0);
    check("R1 valid", int'(resultValid), 0);
    check("R1 ch0", int'(ch0Result), 0);
    check("R1 ch1", int'(ch1Result), 0);
  endtask

  task automatic test_first_frame();
    int v0 = validCnt;
    sclkRises = 0;
    run_conv(100, -200);
    check("R6 no valid on first frame", validCnt - v0, 0);
    check("R6 ch0 unchanged", int'(ch0Result), 0);
    check("R2 strobe width", convWidth, DIV);
    check("R3 serial clock rises", sclkRises, PERS);
  endtask

  task automatic conv_expect(string tag, int a, int b, int expA, int expB);
    int v0 = validCnt;
    run_conv(a, b);
    check({tag, " R7 one valid"}, validCnt - v0, 1);
    check({tag, " R5 R4 ch0"}, int'(capA), expA);
    check({tag, " R5 R4 ch1"}, int'(capB), expB);
  endtask

  task automatic test_patterns();
    conv_expect("latency", -8192, 8191, 100, -200);
    conv_expect("extremes", 0, -1, -8192, 8191);
    conv_expect("zero/neg1", 5461, -5462, 0, -1);
  endtask

  task automatic test_busy_ignore();
    int s0 = strobeCnt;
    int v0 = validCnt;
    nextA = W'(300); nextB = W'(-300);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (50) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 single strobe", strobeCnt - s0, 1);
    check("R10 busy length", busyLast, EXP_BUSY);
    check("R8 valid count", validCnt - v0, 1);
    check("R8 ch0", int'(capA), 5461);
    check("R8 ch1", int'(capB), -5462);
  endtask

  task automatic test_spacing();
    int s0 = strobeCnt;
    int v0 = validCnt;
    nextA = W'(77); nextB = W'(-77);
    @(negedge clk) startReq = 1'b1;
    while (strobeCnt < s0 + 2) @(negedge clk);
    startReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R9 spacing", lastSpacing, EXP_SPACING);
    check("R9 valid count", validCnt - v0, 2);
    check("R5 back-to-back ch0", int'(capA), 77);
    check("R5 back-to-back ch1", int'(capB), -77);
  endtask

  task automatic test_reset_mid();
    int v0;
    nextA = W'(11); nextB = W'(22);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after mid reset", int'(busy), 0);
    check("R1 serclk after mid reset", int'(serClk), 0);
    check("R1 ch0 after mid reset", int'(ch0Result), 0);
    v0 = validCnt;
    run_conv(1234, -1234);
    check("R6 no valid after mid reset", validCnt - v0, 0);
    conv_expect("post-reset", 7, 7, 1234, -1234);
  endtask

  initial begin
    test_reset();
    test_first_frame();
    test_patterns();
    test_busy_ignore();
    test_spacing();
    test_reset_mid();
    check("R7 valid width", widthBad, 0);
    check("R3 serclk idle", idleBad, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
    end
  end
endmodule